// File: doc/BRIEF.md
# Bus Buffer Connection Controller

This block makes the join decision for a bidirectional two-wire bus buffer. The buffer has an input side and an output side, and each side carries a clock line and a data line. The block watches both sides and closes the link only when each side has reached a safe boundary in the same clock cycle. A safe boundary is either a stop condition or a stretch of idle bus. While the link is open, the block keeps the lines precharged. Once the link is closed, it raises a ready flag and enables the edge accelerators.

The block opens the link whenever any of these holds:
- the supply flag reports low voltage;
- the enable input is low;
- an external stuck-bus monitor reports a fault.

After a fault clears, the block must see a fresh safe boundary on both sides before it closes the link again. There is one exception. If enable is dropped and raised again after a fault, the link closes at once, whatever the bus is doing.

The four bus lines are asynchronous and each passes through a two-flop synchronizer. The supply flag, enable and fault flag are taken as synchronous to `clk`.

A single Moore machine holds the state and has four states:
- **OFF**: power is bad or enable is low.
- **WAIT**: the block is looking for safe boundaries.
- **LINK**: the sides are joined.
- **FAULT**: the bus is stuck.

It has these transitions:
- any state → OFF when power is bad or enable is low;
- OFF → WAIT on enable;
- OFF → LINK on enable with a fault remembered (the forced join);
- WAIT → LINK when both sides qualify;
- WAIT → FAULT on fault;
- LINK → FAULT on fault;
- FAULT → WAIT when the fault clears.

Top module: `bbc_ctrl`

## Requirements
- R1: While `pwr_good` is low, the bus pins have no effect. After the first rising edge of `clk` that samples `pwr_good` low, `connect`, `ready` and `accel_en` are 0 and `precharge_en` is 1. Losing power also clears the remembered fault.
- R2: After the first rising edge that samples `enable` low, the link is open: `connect`, `ready` and `accel_en` are 0 and `precharge_en` is 1.
- R3: A side qualifies when either of these holds:
  - on its synchronized lines, SDA was sampled low and is now sampled high while SCL is sampled high (a stop condition);
  - SCL and SDA have both been sampled high for `IDLE_CYCLES` consecutive cycles. The count restarts while the machine is in OFF or FAULT.
- R4: With enable high and power good, the link closes from WAIT only in a cycle in which both sides qualify. If one side stays busy (SCL held low), the link never closes.
- R5: When the link closes, `connect`, `ready` and `accel_en` rise together and `precharge_en` falls in the same cycle.
- R6: A high `fault` in WAIT or LINK opens the link at the next edge, and the link stays open while `fault` stays high.
- R7: After `fault` falls, the machine returns to WAIT and needs a fresh qualification on both sides. Idle time counted during the fault does not count.
- R8: If a fault has occurred and has not been followed by a closed link or a power loss, then enable going low and then high closes the link at the first edge with enable high, even on a busy bus. Without a remembered fault, the same toggle goes through WAIT.
- R9: When power comes up with a side held low, the link stays open. A later fault report and bus release lead to a normal requalification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above lockout threshold (synchronous) |
| enable | input | 1 | Enable pin (synchronous) |
| fault | input | 1 | Stuck-bus fault from external monitor (synchronous) |
| in_scl | input | 1 | Input-side clock line level (asynchronous) |
| in_sda | input | 1 | Input-side data line level (asynchronous) |
| out_scl | input | 1 | Output-side clock line level (asynchronous) |
| out_sda | input | 1 | Output-side data line level (asynchronous) |
| connect | output | 1 | Join the two sides |
| ready | output | 1 | Link is established |
| precharge_en | output | 1 | Enable line precharge |
| accel_en | output | 1 | Enable rise-time accelerators |

## Verification
The assertions assume that `pwr_good`, `enable` and `fault` change only between clock edges, in step with `clk`. They also assume that a forced join is never requested while `fault` is still high. The bench drives every input on the falling edge of `clk`. It keeps `fault` low whenever it toggles enable to force a join. The bus lines may change in any cycle, because they pass through the synchronizer before any decision is made.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LINK  = 2'd2,
        ST_FAULT = 2'd3
    } bbc_state_e;

    localparam int unsigned BBC_SIDES = 2;

endpackage

// File: rtl/bbc_sync.sv
module bbc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bbc_side_qual.sv
module bbc_side_qual #(
    parameter int unsigned IDLE_CYCLES = 23750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic scl,
    input  logic sda,
    output logic qual
);
    localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic          sda_prev;
    logic [CW-1:0] hi_cnt;
    logic          stop_hit;
    logic          idle_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev <= 1'b0;
            hi_cnt   <= '0;
        end else begin
            sda_prev <= sda;
            if (clr) begin
                hi_cnt <= '0;
            end else if (scl && sda) begin
                hi_cnt <= (hi_cnt == LIMIT) ? hi_cnt : hi_cnt + CW'(1);
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    always_comb begin
        stop_hit = scl && sda && !sda_prev;
        idle_hit = (hi_cnt == LIMIT);
        qual     = stop_hit || idle_hit;
    end
endmodule

// File: rtl/bbc_fsm.sv
module bbc_fsm
    import bbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic enable,
    input  logic fault,
    input  logic both_qual,
    output logic link,
    output logic precharge_en,
    output logic mon_clear,
    output logic fault_mem
);
    bbc_state_e state_q, state_d;
    logic       fmem_q, fmem_d;

    // next state
    always_comb begin
        state_d = state_q;
        fmem_d  = fmem_q;
        if (!pwr_good) begin
            state_d = ST_OFF;
            fmem_d  = 1'b0;
        end else if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (fmem_q) begin
                        state_d = ST_LINK;
                        fmem_d  = 1'b0;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (fault) begin
                        state_d = ST_FAULT;
                        fmem_d  = 1'b1;
                    end else if (both_qual) begin
                        state_d = ST_LINK;
                        fmem_d  = 1'b0;
                    end
                end
                ST_LINK: begin
                    if (fault) begin
                        state_d = ST_FAULT;
                        fmem_d  = 1'b1;
                    end
                end
                ST_FAULT: begin
                    if (!fault) state_d = ST_WAIT;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            fmem_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fmem_q  <= fmem_d;
        end
    end

    // outputs
    always_comb begin
        link         = 1'b0;
        precharge_en = 1'b1;
        mon_clear    = 1'b0;
        unique case (state_q)
            ST_OFF:   mon_clear = 1'b1;
            ST_WAIT:  mon_clear = 1'b0;
            ST_LINK: begin
                link         = 1'b1;
                precharge_en = 1'b0;
            end
            ST_FAULT: mon_clear = 1'b1;
            default:  mon_clear = 1'b1;
        endcase
        fault_mem = fmem_q;
    end
endmodule

// File: rtl/bbc_ctrl.sv
module bbc_ctrl
    import bbc_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 23750,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic enable,
    input  logic fault,
    input  logic in_scl,
    input  logic in_sda,
    input  logic out_scl,
    input  logic out_sda,
    output logic connect,
    output logic ready,
    output logic precharge_en,
    output logic accel_en
);
    localparam int unsigned LINES = 2 * BBC_SIDES;

    logic [LINES-1:0]     raw_lines;
    logic [LINES-1:0]     sync_lines;
    logic [BBC_SIDES-1:0] scl_s;
    logic [BBC_SIDES-1:0] sda_s;
    logic [BBC_SIDES-1:0] side_qual;
    logic                 both_qual;
    logic                 mon_clear;
    logic                 link;
    logic                 pre_en;
    logic                 fault_mem;

    // side 0 = input side, side 1 = output side
    assign raw_lines = {out_scl, in_scl, out_sda, in_sda};

    bbc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    assign scl_s = sync_lines[LINES-1:BBC_SIDES];
    assign sda_s = sync_lines[BBC_SIDES-1:0];

    for (genvar s = 0; s < BBC_SIDES; s++) begin : g_side
        bbc_side_qual #(.IDLE_CYCLES(IDLE_CYCLES)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mon_clear),
            .scl   (scl_s[s]),
            .sda   (sda_s[s]),
            .qual  (side_qual[s])
        );
    end

    assign both_qual = &side_qual;

    bbc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .enable       (enable),
        .fault        (fault),
        .both_qual    (both_qual),
        .link         (link),
        .precharge_en (pre_en),
        .mon_clear    (mon_clear),
        .fault_mem    (fault_mem)
    );

    assign connect      = link;
    assign ready        = link;
    assign accel_en     = link;
    assign precharge_en = pre_en;
endmodule

// File: rtl/bbc_ctrl_chk.sv
module bbc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic enable,
    input logic fault,
    input logic connect,
    input logic ready,
    input logic precharge_en,
    input logic accel_en,
    input logic both_qual,
    input logic fault_mem
);
    AST_PGOOD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !connect && !ready && precharge_en); // R1

    AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !connect && !accel_en && precharge_en); // R2

    AST_JOIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect) |-> $past(both_qual) || $past(fault_mem)); // R4

    AST_JOIN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect) |-> ready && accel_en && !precharge_en); // R5

    AST_FAULT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        connect && fault |=> !connect); // R6
endmodule

bind bbc_ctrl bbc_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .enable       (enable),
    .fault        (fault),
    .connect      (connect),
    .ready        (ready),
    .precharge_en (precharge_en),
    .accel_en     (accel_en),
    .both_qual    (both_qual),
    .fault_mem    (fault_mem)
);

// File: tb/tb_bbc_ctrl.sv
`timescale 1ns/1ps
module tb_bbc_ctrl;
    localparam int IDLE = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, pg, en, flt;
    logic a_scl, a_sda, b_scl, b_sda;
    logic conn, rdy, pre, acc;

    bbc_ctrl #(.IDLE_CYCLES(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pg), .enable(en), .fault(flt),
        .in_scl(a_scl), .in_sda(a_sda), .out_scl(b_scl), .out_sda(b_sda),
        .connect(conn), .ready(rdy), .precharge_en(pre), .accel_en(acc)
    );

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";

    // behavioural reference: queues model the two-sample line delay
    bit m_scl_q[2][$];
    bit m_sda_q[2][$];
    bit m_prev[2];
    int m_cnt[2];
    int m_st;      // 0 off, 1 wait, 2 link, 3 fault
    bit m_fmem;
    bit m_qual[2];
    bit m_scl_now[2];
    bit m_sda_now[2];
    int m_nst;
    bit m_nf;

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_scl_q[s] = '{0, 0};
            m_sda_q[s] = '{0, 0};
            m_prev[s]  = 0;
            m_cnt[s]   = 0;
        end
        m_st   = 0;
        m_fmem = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int s = 0; s < 2; s++) begin
                m_scl_now[s] = m_scl_q[s][1];
                m_sda_now[s] = m_sda_q[s][1];
                m_qual[s] = (m_cnt[s] == IDLE) ||
                            (m_scl_now[s] && m_sda_now[s] && !m_prev[s]);
            end
            m_nst = m_st;
            m_nf  = m_fmem;
            if (!pg) begin
                m_nst = 0; m_nf = 0;
            end else if (!en) begin
                m_nst = 0;
            end else if (m_st == 0) begin
                m_nst = m_fmem ? 2 : 1;
            end else if (m_st == 1) begin
                if (flt) begin m_nst = 3; m_nf = 1; end
                else if (m_qual[0] && m_qual[1]) m_nst = 2;
            end else if (m_st == 2) begin
                if (flt) begin m_nst = 3; m_nf = 1; end
            end else begin
                if (!flt) m_nst = 1;
            end
            if (m_nst == 2) m_nf = 0;
            for (int s = 0; s < 2; s++) begin
                if (m_st == 0 || m_st == 3) m_cnt[s] = 0;
                else if (m_scl_now[s] && m_sda_now[s]) m_cnt[s] = (m_cnt[s] >= IDLE) ? IDLE : m_cnt[s] + 1;
                else m_cnt[s] = 0;
                m_prev[s] = m_sda_now[s];
            end
            m_scl_q[0].pop_back(); m_scl_q[0].push_front(a_scl);
            m_sda_q[0].pop_back(); m_sda_q[0].push_front(a_sda);
            m_scl_q[1].pop_back(); m_scl_q[1].push_front(b_scl);
            m_sda_q[1].pop_back(); m_sda_q[1].push_front(b_sda);
            m_st   = m_nst;
            m_fmem = m_nf;
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        checks++;
        if (conn !== (m_st == 2) || rdy !== (m_st == 2) ||
            acc !== (m_st == 2) || pre !== (m_st != 2)) begin
            errors++;
            $display("FAIL %s: got conn=%b rdy=%b acc=%b pre=%b, expected link=%0d",
                     tag, conn, rdy, acc, pre, (m_st == 2));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_conn(input bit e, input string req);
        checks++;
        if (conn !== e || pre !== !e) begin
            errors++;
            $display("FAIL %s: connect=%b precharge=%b, expected connect=%b", req, conn, pre, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; pg = 0; en = 0; flt = 0;
        a_scl = 1; a_sda = 1; b_scl = 1; b_sda = 1;
        step(4);
        expect_conn(0, "R1");   // reset state
        rst_n = 1;

        // R1: lockout ignores toggling pins
        tag = "R1"; en = 1;
        for (int i = 0; i < 30; i++) begin
            step(1);
            a_sda = i[0]; b_sda = i[1]; a_scl = i[2] | i[0];
        end
        a_scl = 1; a_sda = 1; b_scl = 1; b_sda = 1;
        step(20);
        expect_conn(0, "R1");

        // R2: enable low keeps link open on idle bus
        tag = "R2"; pg = 1; en = 0;
        step(30);
        expect_conn(0, "R2");

        // R3/R5: idle qualification on both sides
        tag = "R3"; en = 1;
        step(30);
        expect_conn(1, "R3");
        tag = "R5";
        checks++;
        if (!(rdy && acc && !pre)) begin
            errors++;
            $display("FAIL R5: rdy=%b acc=%b pre=%b, expected 1 1 0", rdy, acc, pre);
        end

        // R6: fault opens and holds open
        tag = "R6"; flt = 1;
        step(2);
        expect_conn(0, "R6");
        step(20);
        expect_conn(0, "R6");

        // R7: fresh qualification after fault clears
        tag = "R7"; flt = 0;
        step(4);
        expect_conn(0, "R7");
        step(20);
        expect_conn(1, "R7");

        // R4: one side busy never joins
        tag = "R4"; en = 0;
        step(3);
        b_scl = 0; b_sda = 0; en = 1;
        step(40);
        expect_conn(0, "R4");
        // stop on output side while input side idle (R3 stop path)
        tag = "R3"; b_scl = 1;
        step(3);
        b_sda = 1;
        step(4);
        expect_conn(1, "R3");

        // R4: other side busy
        tag = "R4"; en = 0;
        step(3);
        a_scl = 0; en = 1;
        step(40);
        expect_conn(0, "R4");
        a_scl = 1;
        step(30);
        expect_conn(1, "R4");

        // R8: forced join after fault with busy bus
        tag = "R8"; flt = 1;
        step(3);
        b_scl = 0; flt = 0;
        step(5);
        expect_conn(0, "R8");
        en = 0;
        step(2);
        en = 1;
        step(1);
        expect_conn(1, "R8");
        step(10);
        expect_conn(1, "R8");
        // toggle without remembered fault does not force
        en = 0;
        step(2);
        en = 1;
        step(20);
        expect_conn(0, "R8");

        // R9: power up into a held-low side
        tag = "R9"; pg = 0;
        step(3);
        b_sda = 0; pg = 1;
        step(50);
        expect_conn(0, "R9");
        flt = 1;
        step(3);
        expect_conn(0, "R9");
        flt = 0; b_scl = 1; b_sda = 1;
        step(30);
        expect_conn(1, "R7");

        // R1: power loss drops link within one clock
        tag = "R1"; pg = 0;
        step(1);
        expect_conn(0, "R1");
        step(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule